// File: doc/BRIEF.md
# Programmable Chip-Select Decoder

This block turns the address and strobes of an 8-bit processor into four chip-select lines. Each select channel owns a mask byte and a compare byte, both written by software through a small register port. Bits 1:0 of the mask are control bits: an enable and a space flag that picks memory or I/O. Bits 7:2 of the mask choose which address bits take part in the match. For a memory access the upper address byte is compared; for an I/O access the 8-bit port address is compared. A window therefore has a size of at least 1 KB in memory space, or four ports in I/O space.

After reset every channel is cleared and the decoder starts in a start-up mode. In that mode, select 0 (the boot ROM channel) answers every memory read, so the processor can fetch code before any channel has been set up. Software programs the channels, then writes the control register with bit 0 clear to leave start-up mode. When more than one channel matches, the lowest-numbered channel wins and only that line is driven. In normal use channel 0 holds ROM, channel 1 RAM, channel 2 an interrupt controller and channel 3 a serial port.

Top module: `csel_decoder`

## Requirements
- R1: After reset every mask and compare byte is 0x00 and start-up mode is active: a memory read asserts only select 0, and every other access asserts no select.
- R2: A channel whose mask bit 0 (enable) is 0 never asserts its select, whatever the address.
- R3: Mask bit 1 picks the space of a channel (1 = I/O, 0 = memory). A memory access (mem_rd or mem_wr) never asserts an I/O channel, and an I/O access (io_rd or io_wr) never asserts a memory channel. With no strobe active, no select asserts.
- R4: A memory channel matches when (cpu_addr[15:8] AND mask) equals (compare AND mask), taken over bits 7:2 only. Mask 0xF1 therefore gives a 4 KB window and mask 0xFD gives a 1 KB window.
- R5: An I/O channel matches when (cpu_addr[7:0] AND mask) equals (compare AND mask) over bits 7:2. cpu_addr[15:8] is ignored, and mask 0xFF gives a block of 4 consecutive ports.
- R6: When several channels match, only the lowest-numbered one asserts. At most one select is high at any time.
- R7: In start-up mode, a memory read asserts select 0 and no other select, whatever the channel registers hold. Memory writes and I/O accesses decode normally.
- R8: A write to the control register loads the start-up flag from data bit 0. Writing 0x00 leaves start-up mode, and writing 0x01 enters it again, from the next cycle on.
- R9: Register offsets: 0 is the control register. Channel n (n = 0..3) has its mask at offset 2n+2 and its compare at offset 2n+3. A write takes effect at the clock edge where reg_wr is high, and nothing is written while reg_wr is low.
- R10: Writes to offset 1 or to offsets 10 to 15 change no channel and do not change the start-up flag.
- R11: If a memory strobe and an I/O strobe are active together, no select asserts.
- R12: The selects are combinational in the address and strobes: they are valid in the same cycle as the access.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register file |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| sel_o | output | 4 | Chip-select lines, bit 0 = channel 0 |

## Verification
The selects are combinational, so a wrong mask, compare or start-up flag shows up on sel_o in the first access cycle after the bad state appears. A stuck start-up flag makes select 0 answer a memory read that should go to RAM or to nothing. A compare byte written to the wrong offset moves a window, which shows on the accesses placed at both edges of that window. A priority fault shows as two selects high at once, or as the wrong channel winning on an address that two channels both cover.

// File: rtl/csel_pkg.sv
package csel_pkg;
   // control bits held in the low bits of every mask byte
   localparam int EN_BIT    = 0;
   localparam int SPACE_BIT = 1;
   localparam int CTRL_BITS = 2;
   // control register offset
   localparam int MAIN_OFF  = 0;

   typedef enum logic {SPACE_MEM = 1'b0, SPACE_IO = 1'b1} space_e;

   function automatic int mask_off(input int ch);
      return 2 + 2 * ch;
   endfunction

   function automatic int cmp_off(input int ch);
      return 3 + 2 * ch;
   endfunction
endpackage

// File: rtl/csel_regfile.sv
module csel_regfile
   import csel_pkg::*;
#(
   parameter int N_SEL  = 4,
   parameter int DATA_W = 8,
   parameter int RA_W   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic [RA_W-1:0]            reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [N_SEL-1:0][DATA_W-1:0] mask_q,
   output logic [N_SEL-1:0][DATA_W-1:0] cmp_q,
   output logic                       boot_q
);
   localparam int TOP_OFF = cmp_off(N_SEL - 1);

   if (TOP_OFF >= (1 << RA_W)) begin : g_bad_ra
      $error("csel_regfile: RA_W too small for N_SEL channels");
   end

   logic main_we;
   assign main_we = reg_wr && (reg_addr == RA_W'(MAIN_OFF));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         boot_q <= 1'b1;
      end else if (main_we) begin
         boot_q <= reg_wdata[0];
      end
   end

   for (genvar ch = 0; ch < N_SEL; ch++) begin : g_ch
      logic mask_we, cmp_we;
      assign mask_we = reg_wr && (reg_addr == RA_W'(mask_off(ch)));
      assign cmp_we  = reg_wr && (reg_addr == RA_W'(cmp_off(ch)));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[ch] <= '0;
            cmp_q[ch]  <= '0;
         end else begin
            if (mask_we) mask_q[ch] <= reg_wdata;
            if (cmp_we)  cmp_q[ch]  <= reg_wdata;
         end
      end
   end
endmodule

// File: rtl/csel_match.sv
module csel_match
   import csel_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PORT_W = 8,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              mem_acc,
   input  logic              io_acc,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] cmp,
   output logic              hit
);
   localparam int HI_LSB = ADDR_W - DATA_W;

   if (PORT_W != DATA_W) begin : g_bad_port
      $error("csel_match: PORT_W must equal DATA_W");
   end
   if (ADDR_W < DATA_W) begin : g_bad_addr
      $error("csel_match: ADDR_W smaller than DATA_W");
   end

   logic [DATA_W-1:0] care;
   logic [DATA_W-1:0] probe;
   logic              space_io;
   logic              kind_ok;

   assign care     = {mask[DATA_W-1:CTRL_BITS], {CTRL_BITS{1'b0}}};
   assign space_io = (mask[SPACE_BIT] == SPACE_IO);
   assign probe    = space_io ? addr[PORT_W-1:0] : addr[ADDR_W-1:HI_LSB];
   assign kind_ok  = space_io ? io_acc : mem_acc;
   assign hit      = mask[EN_BIT] && kind_ok && ((probe & care) == (cmp & care));
endmodule

// File: rtl/csel_prio.sv
module csel_prio #(
   parameter int N_SEL     = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N_SEL-1:0] req,
   output logic [N_SEL-1:0] gnt
);
   if (LOW_FIRST) begin : g_low
      always_comb begin
         gnt = '0;
         for (int i = N_SEL - 1; i >= 0; i--) begin
            if (req[i]) gnt = N_SEL'(1) << i;
         end
      end
   end else begin : g_high
      always_comb begin
         gnt = '0;
         for (int i = 0; i < N_SEL; i++) begin
            if (req[i]) gnt = N_SEL'(1) << i;
         end
      end
   end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
   import csel_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int PORT_W    = 8,
   parameter int DATA_W    = 8,
   parameter int N_SEL     = 4,
   parameter int RA_W      = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [N_SEL-1:0]  sel_o
);
   localparam int BOOT_CH = 0;

   if (N_SEL < 1) begin : g_bad_n
      $error("csel_decoder: N_SEL must be at least 1");
   end
   if (DATA_W <= CTRL_BITS) begin : g_bad_dw
      $error("csel_decoder: DATA_W must exceed the control bits");
   end

   logic [N_SEL-1:0][DATA_W-1:0] mask_q;
   logic [N_SEL-1:0][DATA_W-1:0] cmp_q;
   logic                         boot_q;
   logic                         mem_any, io_any;
   logic                         mem_acc, io_acc;
   logic                         boot_force;
   logic [N_SEL-1:0]             hit;
   logic [N_SEL-1:0]             req;

   csel_regfile #(
      .N_SEL (N_SEL),
      .DATA_W(DATA_W),
      .RA_W  (RA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .mask_q   (mask_q),
      .cmp_q    (cmp_q),
      .boot_q   (boot_q)
   );

   // a cycle with strobes of both spaces is treated as no access
   assign mem_any    = mem_rd | mem_wr;
   assign io_any     = io_rd | io_wr;
   assign mem_acc    = mem_any & ~io_any;
   assign io_acc     = io_any & ~mem_any;
   assign boot_force = boot_q & mem_rd & ~io_any;

   for (genvar ch = 0; ch < N_SEL; ch++) begin : g_match
      csel_match #(
         .ADDR_W(ADDR_W),
         .PORT_W(PORT_W),
         .DATA_W(DATA_W)
      ) u_match (
         .addr   (cpu_addr),
         .mem_acc(mem_acc),
         .io_acc (io_acc),
         .mask   (mask_q[ch]),
         .cmp    (cmp_q[ch]),
         .hit    (hit[ch])
      );
   end

   // start-up mode: boot channel alone answers memory reads
   always_comb begin
      req = hit;
      if (boot_force) req = N_SEL'(1) << BOOT_CH;
   end

   csel_prio #(
      .N_SEL    (N_SEL),
      .LOW_FIRST(LOW_FIRST)
   ) u_prio (
      .req(req),
      .gnt(sel_o)
   );
endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk #(
   parameter int N_SEL  = 4,
   parameter int DATA_W = 8,
   parameter int RA_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              io_rd,
   input logic              io_wr,
   input logic              reg_wr,
   input logic [RA_W-1:0]   reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              boot_q,
   input logic [N_SEL-1:0]  sel_o
);
   p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd || mem_wr || io_rd || io_wr) |-> sel_o == '0);

   p_mixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && (io_rd || io_wr)) |-> sel_o == '0);

   p_boot_rom_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_q && mem_rd && !io_rd && !io_wr) |-> sel_o == N_SEL'(1));

   p_main_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == '0) |=> boot_q == $past(reg_wdata[0]));

   p_keep_boot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == '0) |=> $stable(boot_q));
endmodule

bind csel_decoder csel_decoder_chk #(
   .N_SEL (N_SEL),
   .DATA_W(DATA_W),
   .RA_W  (RA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .io_rd    (io_rd),
   .io_wr    (io_wr),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .boot_q   (boot_q),
   .sel_o    (sel_o)
);

// File: tb/csel_decoder_test.sv
module csel_decoder_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        mem_rd = 1'b0, mem_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [3:0]  sel_o;

   int checks = 0;
   int bad = 0;
   bit done = 0;

   logic [3:0] q_exp[$];
   string      q_tag[$];

   always #(CLK_P / 2) clk = ~clk;

   csel_decoder uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .sel_o(sel_o)
   );

   // monitor: compare in the middle of each access cycle
   always @(negedge clk) begin
      if (q_exp.size() > 0) begin
         logic [3:0] e;
         string      t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         checks++;
         if (sel_o !== e) begin
            bad++;
            $display("FAIL %s: sel_o=%b expected=%b", t, sel_o, e);
         end
      end
   end

   // strobe code: {mem_rd, mem_wr, io_rd, io_wr}
   task automatic access(input logic [15:0] a, input logic [3:0] stb,
                         input logic [3:0] exp, input string tag);
      @(posedge clk); #1;
      cpu_addr = a;
      {mem_rd, mem_wr, io_rd, io_wr} = stb;
      q_exp.push_back(exp);
      q_tag.push_back(tag);
   endtask

   task automatic wreg(input logic [3:0] off, input logic [7:0] d, input logic we);
      @(posedge clk); #1;
      {mem_rd, mem_wr, io_rd, io_wr} = 4'b0000;
      reg_wr = we; reg_addr = off; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   localparam logic [3:0] MR = 4'b1000, MW = 4'b0100, IR = 4'b0010, IW = 4'b0001;

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog: sel_o=%b expected=finish", sel_o);
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      access(16'h1234, MR, 4'b0001, "R1 reset memory read");
      access(16'h0020, IR, 4'b0000, "R1 reset io read");
      access(16'h1234, MW, 4'b0000, "R7 boot memory write not forced");
      access(16'h0000, 4'b0000, 4'b0000, "R3 no strobe");
      // program: ch0 ROM 4KB @0, ch1 RAM 1KB @0x1000, ch2 io 0x10-1F, ch3 io 0x20-23
      wreg(4'd2, 8'hF1, 1'b1); wreg(4'd3, 8'h00, 1'b1);
      wreg(4'd4, 8'hFD, 1'b1); wreg(4'd5, 8'h10, 1'b1);
      wreg(4'd6, 8'hF3, 1'b1); wreg(4'd7, 8'h10, 1'b1);
      wreg(4'd8, 8'hFF, 1'b1); wreg(4'd9, 8'h20, 1'b1);
      access(16'h1000, MR, 4'b0001, "R7 boot forces channel 0");
      access(16'h1000, MW, 4'b0010, "R7 boot write decodes RAM");
      wreg(4'd0, 8'h00, 1'b0);
      access(16'h1000, MR, 4'b0001, "R9 no write without reg_wr");
      wreg(4'd0, 8'h00, 1'b1);
      access(16'h1000, MR, 4'b0010, "R8 exit boot RAM read");
      access(16'h0FFF, MR, 4'b0001, "R4 ROM top");
      access(16'h13FF, MR, 4'b0010, "R4 RAM top");
      access(16'h1400, MR, 4'b0000, "R4 past RAM");
      access(16'h8000, MR, 4'b0000, "R4 unmapped");
      access(16'h0023, IR, 4'b1000, "R5 serial port");
      access(16'hAB23, IW, 4'b1000, "R5 io high byte ignored");
      access(16'h0024, IR, 4'b0000, "R5 past serial block");
      access(16'h001F, IR, 4'b0100, "R5 io 16 port block");
      access(16'h0020, MR, 4'b0001, "R3 memory misses io channel");
      access(16'h0000, IR, 4'b0000, "R3 io misses memory channel");
      access(16'h0020, MR | IR, 4'b0000, "R11 mixed strobes");
      access(16'h1000, MW | IW, 4'b0000, "R11 mixed writes");
      // overlap: ch1 moved onto ROM region
      wreg(4'd5, 8'h00, 1'b1);
      access(16'h0100, MR, 4'b0001, "R6 lowest channel wins");
      wreg(4'd2, 8'hF0, 1'b1);
      access(16'h0100, MR, 4'b0010, "R2 disabled channel 0");
      access(16'h0800, MR, 4'b0000, "R2 disabled channel no hit");
      wreg(4'd1, 8'hFF, 1'b1);
      wreg(4'd10, 8'hFF, 1'b1);
      wreg(4'd15, 8'h01, 1'b1);
      access(16'h0800, MR, 4'b0000, "R10 stray writes ignored");
      access(16'h0100, MR, 4'b0010, "R10 channel 1 intact");
      access(16'h8000, MR, 4'b0000, "R10 boot still off");
      wreg(4'd0, 8'h01, 1'b1);
      access(16'h8000, MR, 4'b0001, "R8 boot re-entered");
      access(16'h0022, IR, 4'b1000, "R12 io decoded same cycle");
      @(posedge clk); #1;
      {mem_rd, mem_wr, io_rd, io_wr} = 4'b0000;
      @(posedge clk);
      @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule